// File: doc/BRIEF.md
# Watchdog Timer with Trip Counter

This block supervises system software. Software programs a 32-bit timeout, enables the watchdog, and from then on has to service it before the timeout runs out. A timeout that runs out without service is an expiration. The down-counter reloads itself and a trip counter advances. When the trip counter reaches a programmed limit, a reset request output is raised. It stays high until an explicit release.

The configuration registers are behind a key. The control, timeout and limit registers accept writes only while a fixed 32-bit key sits in the key register. Writing any other value to the key register locks the space again. The running count and the trip count are read-only.

Counting advances on a watchdog tick enable input, `wd_tick`, which is sampled on the block clock. The register port is single-cycle: a write strobe with a word address and 32-bit data, and combinational read data taken from the same address.

The control sequencer has three states:
- `WD_IDLE` is the state after system reset. In it the watchdog is disabled.
- `WD_RUN` counts ticks.
- `WD_TRIP` drives the reset request.

It has five transitions:
- The arm transition goes from WD_IDLE to WD_RUN on an unlocked write that sets the enable bit.
- The stop transition goes from WD_RUN to WD_IDLE on an unlocked write that clears the enable bit.
- The fire transition goes from WD_RUN to WD_TRIP on the expiration that brings the trip count to the limit.
- The release transition goes from WD_TRIP to WD_IDLE on an unlocked write that clears the enable bit.
- The service hold keeps WD_RUN on a service write and reloads the counter.

Top module: `wdog_trip`

## Requirements
- R1: After system reset `wd_reset_out` is 0 and the block is disabled and locked. Reads return 0 at word 0 (control), word 2 (running count), word 6 (trip count) and word 4 (key status). Word 1 (timeout) reads 0xFFFFFFFF. Word 3 (trip limit) reads 1.
- R2: Writing 0x5A5AC3C3 to word 4 unlocks the space, and word 4 then reads 1. Writing any other value to word 4 locks it, and word 4 then reads 0.
- R3: While locked, writes to word 0, word 1 and word 3 leave those registers unchanged. A write to word 2 never changes the running count.
- R4: An unlocked write to word 0 with bit 0 set, made while disabled, enables the watchdog. In the same cycle it loads the running count from the timeout and clears the trip count. Word 0 bit 0 then reads 1.
- R5: While running, each tick decrements the running count by one. A tick that finds the count at 1 or 0 is an expiration: the count reloads from the timeout and the trip count increases by one. A timeout of N therefore expires every N ticks.
- R6: A write of any data to word 5 while running, locked or not, reloads the running count and clears the trip count. It takes priority over a tick in the same cycle.
- R7: `wd_reset_out` rises on the expiration that makes the trip count equal to the trip limit. A limit of 0 acts as 1.
- R8: Once high, `wd_reset_out` stays high, the counters freeze, and service writes are ignored. It clears only on system reset or on an unlocked write of 0 to word 0, which returns the block to disabled.
- R9: An unlocked write of 0 to word 0 while running disables the watchdog. Later ticks leave the running count unchanged.
- R10: Read addresses 7 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 3 | Word address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| wd_tick | input | 1 | Watchdog count enable, one per watchdog period |
| wd_reset_out | output | 1 | Sticky reset request |

## Verification
The countdown is tried at three points:
- Partial tick runs, which show a plain decrement from the length of the period.
- A run that crosses the reload point, which separates an N-tick period from an N+1-tick one.
- Service writes, which tell a real reload apart from a count that only happened to match. One of them coincides with a tick, which exposes the priority.

The trip path is tried with two limits:
- A limit of three, checked one tick before and on the firing tick, which pins the exact firing expiration.
- A limit of zero, which separates the one-expiration rule from a limit that would never fire.

Writes are repeated while locked, with a wrong key, and while tripped. These separate ignored writes from accepted ones, and a real release from a sticky output that merely stays set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CUR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd3;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd4;
    localparam logic [ADDR_W-1:0] A_SVC   = 3'd5;
    localparam logic [ADDR_W-1:0] A_TRIPS = 3'd6;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY  = 32'h5A5A_C3C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] limit_val,
    output logic              ctrl_wr,
    output logic              ctrl_en,
    output logic              svc_wr
);
    localparam logic [DATA_W-1:0] LOAD_RST  = '1;
    localparam logic [DATA_W-1:0] LIMIT_RST = DATA_W'(1);

    logic open_wr;
    assign open_wr = wr_en && unlocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked  <= 1'b0;
            load_val  <= LOAD_RST;
            limit_val <= LIMIT_RST;
        end else begin
            if (wr_en && addr == A_KEY)    unlocked  <= (wdata == KEY);
            if (open_wr && addr == A_LOAD)  load_val  <= wdata;
            if (open_wr && addr == A_LIMIT) limit_val <= wdata;
        end
    end

    assign ctrl_wr = open_wr && addr == A_CTRL;
    assign ctrl_en = wdata[0];
    assign svc_wr  = wr_en && addr == A_SVC;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              svc_wr,
    input  logic              tick,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit_val,
    output logic [DATA_W-1:0] cur_val,
    output logic [DATA_W-1:0] trip_cnt,
    output logic              enabled,
    output logic              tripped
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    wd_state_e state, state_nx;
    logic [DATA_W-1:0] eff_lim, trips_inc;
    logic              expire;

    assign eff_lim   = (limit_val == '0) ? ONE : limit_val;
    assign trips_inc = trip_cnt + ONE;
    assign expire    = tick && (cur_val <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_IDLE: if (ctrl_wr && ctrl_en) state_nx = WD_RUN;
            WD_RUN: begin
                if (ctrl_wr && !ctrl_en)                 state_nx = WD_IDLE;
                else if (svc_wr)                         state_nx = WD_RUN;
                else if (expire && trips_inc >= eff_lim) state_nx = WD_TRIP;
            end
            WD_TRIP: if (ctrl_wr && !ctrl_en) state_nx = WD_IDLE;
            default: state_nx = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_val  <= '0;
            trip_cnt <= '0;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    if (ctrl_wr && ctrl_en) begin
                        cur_val  <= load_val;
                        trip_cnt <= '0;
                    end
                end
                WD_RUN: begin
                    if (ctrl_wr && !ctrl_en) begin
                        cur_val <= cur_val;
                    end else if (svc_wr) begin
                        cur_val  <= load_val;
                        trip_cnt <= '0;
                    end else if (tick) begin
                        if (cur_val <= ONE) begin
                            cur_val  <= load_val;
                            trip_cnt <= trips_inc;
                        end else begin
                            cur_val <= cur_val - ONE;
                        end
                    end
                end
                WD_TRIP: begin
                    cur_val <= cur_val;
                end
                default: begin
                    cur_val <= cur_val;
                end
            endcase
        end
    end

    always_comb begin
        enabled = (state != WD_IDLE);
        tripped = (state == WD_TRIP);
    end
endmodule

// File: rtl/wdog_trip.sv
module wdog_trip
    import wdt_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h5A5A_C3C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wd_tick,
    output logic              wd_reset_out
);
    logic              unlocked, ctrl_wr, ctrl_en, svc_wr, enabled, tripped;
    logic [DATA_W-1:0] load_val, limit_val, cur_val, trip_cnt;

    wdt_cfg #(.DATA_W(DATA_W), .KEY(KEY)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .unlocked(unlocked), .load_val(load_val), .limit_val(limit_val),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .svc_wr(svc_wr)
    );

    wdt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .svc_wr(svc_wr), .tick(wd_tick), .load_val(load_val),
        .limit_val(limit_val), .cur_val(cur_val), .trip_cnt(trip_cnt),
        .enabled(enabled), .tripped(tripped)
    );

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = DATA_W'(enabled);
            A_LOAD:  rdata = load_val;
            A_CUR:   rdata = cur_val;
            A_LIMIT: rdata = limit_val;
            A_KEY:   rdata = DATA_W'(unlocked);
            A_TRIPS: rdata = trip_cnt;
            default: rdata = '0;
        endcase
    end

    assign wd_reset_out = tripped;
endmodule

// File: rtl/wdog_trip_chk.sv
module wdog_trip_chk
    import wdt_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h5A5A_C3C3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wd_tick,
    input logic              wd_reset_out,
    input logic              unlocked,
    input logic              enabled,
    input logic [DATA_W-1:0] load_val,
    input logic [DATA_W-1:0] cur_val,
    input logic [DATA_W-1:0] trip_cnt
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    logic run;
    assign run = enabled && !wd_reset_out;

    p_key_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wdata != KEY) |=> !unlocked);

    p_locked_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOAD && !unlocked) |=> $stable(load_val));

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wd_tick && !wr_en && cur_val > ONE) |=> cur_val == $past(cur_val) - ONE);

    p_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && addr == A_SVC) |=> (cur_val == $past(load_val) && trip_cnt == '0));

    p_fire_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_out) |-> $past(wd_tick));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reset_out && !(wr_en && addr == A_CTRL && unlocked && !wdata[0])) |=> wd_reset_out);
endmodule

bind wdog_trip wdog_trip_chk #(.DATA_W(DATA_W), .KEY(KEY)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wd_tick(wd_tick), .wd_reset_out(wd_reset_out), .unlocked(unlocked),
    .enabled(enabled), .load_val(load_val), .cur_val(cur_val), .trip_cnt(trip_cnt)
);

// File: tb/wdog_trip_test.sv
`timescale 1ns/1ps
module wdog_trip_test;
    localparam logic [31:0] KEY = 32'h5A5A_C3C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        wd_tick = 1'b0;
    logic        wd_reset_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    wdog_trip uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wd_tick(wd_tick), .wd_reset_out(wd_reset_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wd_tick = 1'b1;
            @(negedge clk); wd_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 reset_out", 32'(wd_reset_out), 0);
        rd(3'd0, d); chk("R1 ctrl", d, 0);
        rd(3'd1, d); chk("R1 load", d, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R1 cur", d, 0);
        rd(3'd3, d); chk("R1 limit", d, 1);
        rd(3'd4, d); chk("R1 key", d, 0);
        rd(3'd6, d); chk("R1 trips", d, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(3'd1, 32'd10); rd(3'd1, d); chk("R3 locked load", d, 32'hFFFF_FFFF);
        wr(3'd3, 32'd7);  rd(3'd3, d); chk("R3 locked limit", d, 1);
        wr(3'd0, 32'd1);  rd(3'd0, d); chk("R3 locked ctrl", d, 0);
        wr(3'd4, 32'h1234_5678); rd(3'd4, d); chk("R2 wrong key", d, 0);
        wr(3'd4, KEY); rd(3'd4, d); chk("R2 right key", d, 1);
        wr(3'd1, 32'd10); rd(3'd1, d); chk("R2 unlocked load", d, 10);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(3'd1, 32'd5); wr(3'd3, 32'd3); wr(3'd0, 32'd1);
        rd(3'd0, d); chk("R4 enabled", d, 1);
        rd(3'd2, d); chk("R4 cur loaded", d, 5);
        rd(3'd6, d); chk("R4 trips clear", d, 0);
        ticks(2); rd(3'd2, d); chk("R5 decrement", d, 3);
        ticks(3); rd(3'd2, d); chk("R5 reload", d, 5);
        rd(3'd6, d); chk("R5 trip inc", d, 1);
        wr(3'd2, 32'd99); rd(3'd2, d); chk("R3 cur read-only", d, 5);
    endtask

    task automatic t_service();
        logic [31:0] d;
        ticks(2); rd(3'd2, d); chk("R5 partial", d, 3);
        wr(3'd5, 32'd0);
        rd(3'd2, d); chk("R6 svc reload", d, 5);
        rd(3'd6, d); chk("R6 svc trips", d, 0);
        ticks(1);
        @(negedge clk); wr_en = 1'b1; addr = 3'd5; wd_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; wd_tick = 1'b0;
        rd(3'd2, d); chk("R6 svc beats tick", d, 5);
    endtask

    task automatic t_trip();
        logic [31:0] d, held;
        ticks(14);
        chk("R7 not yet", 32'(wd_reset_out), 0);
        rd(3'd6, d); chk("R7 two trips", d, 2);
        ticks(1);
        chk("R7 fires", 32'(wd_reset_out), 1);
        rd(3'd6, d); chk("R7 trips at limit", d, 3);
        rd(3'd2, held);
        wr(3'd5, 32'd0); ticks(3);
        chk("R8 sticky", 32'(wd_reset_out), 1);
        rd(3'd2, d); chk("R8 frozen", d, held);
        wr(3'd4, 32'd0); wr(3'd0, 32'd0);
        chk("R8 locked release ignored", 32'(wd_reset_out), 1);
        wr(3'd4, KEY); wr(3'd0, 32'd0);
        chk("R8 released", 32'(wd_reset_out), 0);
        rd(3'd0, d); chk("R8 disabled", d, 0);
    endtask

    task automatic t_zero_limit();
        wr(3'd3, 32'd0); wr(3'd1, 32'd2); wr(3'd0, 32'd1);
        ticks(1); chk("R7 zero limit early", 32'(wd_reset_out), 0);
        ticks(1); chk("R7 zero limit fires", 32'(wd_reset_out), 1);
        wr(3'd0, 32'd0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(3'd3, 32'd5); wr(3'd1, 32'd4); wr(3'd0, 32'd1);
        ticks(1); rd(3'd2, d); chk("R9 running", d, 3);
        wr(3'd0, 32'd0); ticks(3);
        rd(3'd2, d); chk("R9 held", d, 3);
        chk("R9 no reset", 32'(wd_reset_out), 0);
        rd(3'd7, d); chk("R10 unmapped", d, 0);
    endtask

    initial begin
        #200_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_count();
        t_service();
        t_trip();
        t_zero_limit();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule